// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This controller gathers 64 interrupt request lines into two banks of 32 and turns them into two processor requests: a normal request `irq` and a fast request `fiq`. Every bank is served by two independent register groups, one that feeds `irq` and one that feeds `fiq`. Each group has its own per-line enable, detection-kind and polarity settings, and its own latches for captured edges. As a result, one line can be routed to the normal request, to the fast request, or to both.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge that samples it, and read data is a combinational function of the address. The raw request lines pass through a two-stage synchronizer before any detection is done. Level-detected lines report their current state. Edge-detected lines are held in a latch until software clears them by writing ones to them. A status word per group shows which pending lines are also enabled, so a handler can scan it for the lowest set bit. Choosing a handler order is left to software.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, every enable, detection-kind and polarity field reads zero, every status word reads zero, and both `irq` and `fiq` are low.
- R2: Byte address bits [7:5] select a group: 0 is the low-bank normal group, 1 is the low-bank fast group, 3 is the high-bank normal group and 4 is the high-bank fast group. Bits [4:2] select a word within the group: 0 input view, 1 enable, 2 clear, 3 detection kind, 4 polarity, 5 status. Words 1, 3 and 4 read back what was written. Word 2 reads zero. Writes to words 0 and 5 have no effect.
- R3: When the detection-kind bit is 0 (level), the pending bit follows the synchronized line, and the status bit equals pending AND enable.
- R4: A polarity bit of 1 inverts the line, so a level-mode source is active while the line is low.
- R5: When the detection-kind bit is 1 (edge), a rising edge sets a latch that stays set after the line falls. Writing 1 to that bit of the clear word clears the latch, and writing 0 leaves it set.
- R6: In edge mode with a polarity bit of 1, a falling edge sets the latch and a rising edge does not.
- R7: An edge is latched even while the line is disabled, and it shows in status once the line is enabled.
- R8: A clear write does not remove a level-mode pending bit while the line stays active.
- R9: If a clear write and a newly detected edge fall in the same cycle, the latch remains set.
- R10: `irq` is the OR of the status bits of both normal groups, and `fiq` is the OR of the status bits of both fast groups.
- R11: Address 0x50 reads a constant revision word, and 0x54 reads a feature word with the source count in bits [7:0] and the bank count in bits [15:8]. Both ignore writes. Words 6 and 7 of each group, slot 2 apart from these two words, and slots 5 to 7 all read zero and ignore writes.
- R12: The input-view word returns the synchronized lines of the group's bank, each XOR-ed with that group's polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Byte address; bits [1:0] are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_in | input | 64 | Raw request lines; bits 31..0 form the low bank and bits 63..32 the high bank |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is the collision of R9: a clear write sampled at the same clock edge that captures a new edge. The stimulus first leaves a latched edge in place and lowers the line. It then raises the line on a falling clock edge and lets two rising edges pass through the synchronizer. It issues the clear on the next falling edge, so the write and the detected edge meet at the third rising edge. A follow-up clear with no edge pending shows that the clear path itself still works.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int GRP_PER_BANK = 2;
    localparam int NUM_GRP      = 4;

    typedef enum logic [2:0] {
        WORD_VIEW   = 3'd0,
        WORD_ENABLE = 3'd1,
        WORD_CLEAR  = 3'd2,
        WORD_KIND   = 3'd3,
        WORD_POLAR  = 3'd4,
        WORD_STATUS = 3'd5
    } grp_word_e;

    localparam logic [2:0] SLOT_MISC  = 3'd2;
    localparam logic [2:0] WORD_REV   = 3'd4;
    localparam logic [2:0] WORD_FEAT  = 3'd5;

    // Address slot for group g: 0,1 low bank; 3,4 high bank.
    function automatic logic [2:0] grp_slot(input int g);
        return 3'(g + ((g >= 2) ? 1 : 0));
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/intc_group.sv
module intc_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_sync,
    input  logic         we_enable,
    input  logic         we_clear,
    input  logic         we_kind,
    input  logic         we_polar,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] view,
    output logic [W-1:0] pend,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic [W-1:0] kind,
    output logic [W-1:0] polar
);
    typedef struct packed {
        logic [W-1:0] enable;
        logic [W-1:0] kind;
        logic [W-1:0] polar;
        logic [W-1:0] prev;
        logic [W-1:0] latch;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [W-1:0] corrected, rise, clr_mask;

    always_comb begin
        corrected = src_sync ^ st_q.polar;
        rise      = corrected & ~st_q.prev;
        clr_mask  = we_clear ? wdata : '0;

        st_d       = st_q;
        st_d.prev  = corrected;
        st_d.latch = (st_q.latch & ~clr_mask) | (rise & st_q.kind);
        if (we_enable) st_d.enable = wdata;
        if (we_kind)   st_d.kind   = wdata;
        if (we_polar)  st_d.polar  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view   = corrected;
    assign pend   = (st_q.kind & st_q.latch) | (~st_q.kind & corrected);
    assign status = pend & st_q.enable;
    assign enable = st_q.enable;
    assign kind   = st_q.kind;
    assign polar  = st_q.polar;
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int          BANK_W      = 32,
    parameter int          NUM_BANKS   = 2,
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] REVISION    = 32'h0001_0300
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_sel,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [BANK_W-1:0]           reg_wdata,
    output logic [BANK_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] src_in,
    output logic                        irq,
    output logic                        fiq
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int N_GRP   = NUM_BANKS * GRP_PER_BANK;
    localparam logic [31:0] FEATURE = {16'h0, 8'(NUM_BANKS), 8'(NUM_SRC)};

    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_sync;
    logic [N_GRP-1:0][BANK_W-1:0] grp_view, grp_pend, grp_status;
    logic [N_GRP-1:0][BANK_W-1:0] grp_en, grp_kind, grp_polar;
    logic [N_GRP-1:0] we_en, we_clr, we_kind, we_pol;

    logic [2:0] slot, word;
    logic       grp_hit;
    logic [1:0] grp_idx;
    logic       unused_addr;

    assign slot        = reg_addr[7:5];
    assign word        = reg_addr[4:2];
    assign unused_addr = ^reg_addr[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (src_in[b*BANK_W +: BANK_W]),
            .sync_out (bank_sync[b])
        );
    end

    // Group decode
    always_comb begin
        grp_hit = 1'b0;
        grp_idx = 2'd0;
        for (int g = 0; g < N_GRP; g++) begin
            if (slot == grp_slot(g)) begin
                grp_hit = 1'b1;
                grp_idx = 2'(g);
            end
        end
    end

    always_comb begin
        we_en   = '0;
        we_clr  = '0;
        we_kind = '0;
        we_pol  = '0;
        if (reg_sel && reg_wr && grp_hit) begin
            case (word)
                WORD_ENABLE: we_en[grp_idx]   = 1'b1;
                WORD_CLEAR:  we_clr[grp_idx]  = 1'b1;
                WORD_KIND:   we_kind[grp_idx] = 1'b1;
                WORD_POLAR:  we_pol[grp_idx]  = 1'b1;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        intc_group #(.W(BANK_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_sync  (bank_sync[g/GRP_PER_BANK]),
            .we_enable (we_en[g]),
            .we_clear  (we_clr[g]),
            .we_kind   (we_kind[g]),
            .we_polar  (we_pol[g]),
            .wdata     (reg_wdata),
            .view      (grp_view[g]),
            .pend      (grp_pend[g]),
            .status    (grp_status[g]),
            .enable    (grp_en[g]),
            .kind      (grp_kind[g]),
            .polar     (grp_polar[g])
        );
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (slot == SLOT_MISC) begin
            if (word == WORD_REV)       reg_rdata = REVISION;
            else if (word == WORD_FEAT) reg_rdata = FEATURE;
        end else if (grp_hit) begin
            case (word)
                WORD_VIEW:   reg_rdata = grp_view[grp_idx];
                WORD_ENABLE: reg_rdata = grp_en[grp_idx];
                WORD_KIND:   reg_rdata = grp_kind[grp_idx];
                WORD_POLAR:  reg_rdata = grp_polar[grp_idx];
                WORD_STATUS: reg_rdata = grp_status[grp_idx];
                default:     reg_rdata = '0;
            endcase
        end
    end

    // Request outputs: even groups normal, odd groups fast
    always_comb begin
        irq = 1'b0;
        fiq = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            if ((g % GRP_PER_BANK) == 0) irq = irq | (|grp_status[g]);
            else                          fiq = fiq | (|grp_status[g]);
        end
    end
endmodule

// File: rtl/intc_dual_bank_chk.sv
module intc_dual_bank_chk
    import intc_pkg::*;
#(
    parameter int W     = 32,
    parameter int N_GRP = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_sel,
    input logic                      reg_wr,
    input logic [7:0]                reg_addr,
    input logic [N_GRP-1:0][W-1:0]   grp_en,
    input logic [N_GRP-1:0][W-1:0]   grp_kind,
    input logic [N_GRP-1:0][W-1:0]   grp_polar,
    input logic [N_GRP-1:0][W-1:0]   grp_pend,
    input logic [N_GRP-1:0][W-1:0]   grp_status
);
    logic       wr_any;
    logic       wr_cfg_slot;
    logic [N_GRP-1:0] wr_grp;

    assign wr_any = reg_sel && reg_wr;

    always_comb begin
        wr_cfg_slot = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            wr_grp[g] = wr_any && (reg_addr[7:5] == grp_slot(g));
            if (reg_addr[7:5] == grp_slot(g) && reg_addr[4:2] < 3'd6) wr_cfg_slot = 1'b1;
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clean_chk: assert (grp_en == '0 && grp_kind == '0 && grp_polar == '0);
        end
    end

    // R11
    reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !wr_cfg_slot) |=> ($stable(grp_en) && $stable(grp_kind) && $stable(grp_polar)));

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        // R3
        status_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_status[g] & ~grp_en[g]) == '0);

        // R5
        edge_latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_grp[g] |=> ((($past(grp_pend[g]) & $past(grp_kind[g])) & ~grp_pend[g]) == '0));
    end
endmodule

bind intc_dual_bank intc_dual_bank_chk #(.W(32), .N_GRP(4)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .grp_en     (grp_en),
    .grp_kind   (grp_kind),
    .grp_polar  (grp_polar),
    .grp_pend   (grp_pend),
    .grp_status (grp_status)
);

// File: tb/intc_dual_bank_tb.sv
`timescale 1ns/1ps
module intc_dual_bank_tb;
    localparam logic [31:0] REV = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] src_in = '0;
    logic        irq, fiq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    bit          q_pins[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    intc_dual_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_in(src_in), .irq(irq), .fiq(fiq)
    );

    // Monitor: compares mid-cycle after the edge that follows each request
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q_exp.size() > 0) begin
                bit          pk;
                logic [31:0] ex, got;
                string       tg;
                pk = q_pins.pop_front();
                ex = q_exp.pop_front();
                tg = q_tag.pop_front();
                got = pk ? {30'b0, irq, fiq} : reg_rdata;
                n_chk++;
                if (got !== ex) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", tg, got, ex);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        q_pins.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic chk_pins(input logic [1:0] e, input string tag);
        q_pins.push_back(1'b1); q_exp.push_back({30'b0, e}); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        chk_rd(8'h04, 32'h0, "R1 low irq enable");
        chk_rd(8'h8C, 32'h0, "R1 high fiq kind");
        chk_rd(8'h70, 32'h0, "R1 high irq polarity");
        chk_rd(8'h14, 32'h0, "R1 low irq status");
        chk_pins(2'b00, "R1 pins");

        // R11 constant and reserved words
        chk_rd(8'h50, REV, "R11 revision");
        chk_rd(8'h54, 32'h0000_0240, "R11 feature");
        wr(8'h50, 32'hFFFF_FFFF);
        chk_rd(8'h50, REV, "R11 revision write ignored");
        wr(8'h40, 32'h1234_5678);
        chk_rd(8'h40, 32'h0, "R11 reserved 0x40");
        wr(8'h18, 32'hFFFF_FFFF);
        chk_rd(8'h18, 32'h0, "R11 reserved group word");
        chk_rd(8'hA4, 32'h0, "R11 beyond map");

        // R2 map and readback
        wr(8'h04, 32'hA5A5_0F0F);
        chk_rd(8'h04, 32'hA5A5_0F0F, "R2 low irq enable readback");
        chk_rd(8'h24, 32'h0, "R2 low fiq enable separate");
        wr(8'h8C, 32'h0000_C003);
        chk_rd(8'h8C, 32'h0000_C003, "R2 high fiq kind readback");
        wr(8'h8C, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h74, 32'hFFFF_FFFF);
        chk_rd(8'h74, 32'h0, "R2 status write ignored");
        chk_rd(8'h08, 32'h0, "R2 clear word reads zero");

        // R12 input view
        src_in = 64'h1357_9BDF_0246_8ACE;
        settle(3);
        chk_rd(8'h00, 32'h0246_8ACE, "R12 low view");
        chk_rd(8'h60, 32'h1357_9BDF, "R12 high view");
        wr(8'h10, 32'hFFFF_0000);
        chk_rd(8'h00, 32'hFDB9_8ACE, "R12 view polarity");
        chk_rd(8'h20, 32'h0246_8ACE, "R12 fast group unaffected");
        wr(8'h10, 32'h0);
        src_in = '0;
        settle(3);

        // R3 level mode, R10 routing to irq only
        src_in[3] = 1'b1;
        wr(8'h04, 32'h0000_0008);
        settle(3);
        chk_rd(8'h14, 32'h0000_0008, "R3 level status");
        chk_pins(2'b10, "R10 irq only");
        // R8 clear cannot remove level
        wr(8'h08, 32'h0000_0008);
        chk_rd(8'h14, 32'h0000_0008, "R8 level survives clear");
        src_in[3] = 1'b0;
        settle(3);
        chk_rd(8'h14, 32'h0, "R3 level released");
        chk_pins(2'b00, "R10 irq drops");
        wr(8'h04, 32'h0);

        // R4 active-low level on source 37 in high fast group
        wr(8'h84, 32'h0000_0020);
        wr(8'h90, 32'h0000_0020);
        settle(3);
        chk_rd(8'h94, 32'h0000_0020, "R4 active low pending");
        chk_pins(2'b01, "R10 fiq from high bank");
        src_in[37] = 1'b1;
        settle(3);
        chk_rd(8'h94, 32'h0, "R4 high line inactive");
        chk_pins(2'b00, "R4 fiq low");
        wr(8'h84, 32'h0);
        wr(8'h90, 32'h0);
        src_in[37] = 1'b0;
        settle(3);

        // R5 rising edge on source 32, high irq group
        wr(8'h6C, 32'h0000_0001);
        wr(8'h64, 32'h0000_0001);
        src_in[32] = 1'b1;
        settle(3);
        src_in[32] = 1'b0;
        settle(3);
        chk_rd(8'h74, 32'h0000_0001, "R5 edge latched");
        chk_pins(2'b10, "R10 irq from high bank");
        wr(8'h68, 32'h0);
        chk_rd(8'h74, 32'h0000_0001, "R5 zero clear no effect");
        wr(8'h68, 32'h0000_0001);
        chk_rd(8'h74, 32'h0, "R5 cleared");
        chk_pins(2'b00, "R5 irq low");

        // R6 falling edge on source 33
        src_in[33] = 1'b1;
        settle(3);
        wr(8'h70, 32'h0000_0002);
        settle(2);
        wr(8'h6C, 32'h0000_0003);
        wr(8'h64, 32'h0000_0003);
        settle(2);
        chk_rd(8'h74, 32'h0, "R6 nothing before fall");
        src_in[33] = 1'b0;
        settle(3);
        chk_rd(8'h74, 32'h0000_0002, "R6 falling latched");
        wr(8'h68, 32'h0000_0002);
        src_in[33] = 1'b1;
        settle(3);
        chk_rd(8'h74, 32'h0, "R6 rise not latched");
        wr(8'h64, 32'h0);

        // R7 edge latched while disabled, source 7 low fast group
        wr(8'h2C, 32'h0000_0080);
        src_in[7] = 1'b1;
        settle(3);
        src_in[7] = 1'b0;
        settle(3);
        chk_rd(8'h34, 32'h0, "R7 disabled hides status");
        chk_pins(2'b00, "R7 fiq low while disabled");
        wr(8'h24, 32'h0000_0080);
        chk_rd(8'h34, 32'h0000_0080, "R7 appears on enable");
        chk_pins(2'b01, "R7 fiq high");

        // R9 clear and new edge in the same cycle
        src_in[7] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(8'h28, 32'h0000_0080);
        chk_rd(8'h34, 32'h0000_0080, "R9 new edge wins");
        wr(8'h28, 32'h0000_0080);
        chk_rd(8'h34, 32'h0, "R9 later clear works");
        src_in[7] = 1'b0;
        settle(3);

        settle(2);
        done = 1'b1;
        finish_run();
    end
endmodule